// File: doc/BRIEF.md
# Raster Timing and Frame Address Generator

This block produces the timing skeleton for a low-resolution raster display driven from a 4 MHz pixel clock. A 7-bit column counter steps through 127 positions per line, which gives a 31.75 µs line. A 10-bit row counter advances each time the column counter wraps, and it spans 525 rows per frame. Together they give line and frame rates that a standard 640×480 60 Hz monitor accepts. The horizontal resolution is coarse: 100 visible columns by default.

The two counts are decoded into several outputs:
- horizontal and vertical sync pulses;
- horizontal and vertical blank flags, which downstream colour logic uses to force its outputs dark;
- a single-column marker, high at column 64, which draws a vertical line when fed straight to a colour input;
- a 17-bit linear frame-buffer address, which is the row count placed above the column count.

The sync pulses are placed so that every horizontal pulse falls inside the vertical pulse and never on one of its edges. All decoded outputs are registered. They are computed from the counters' next state, so they line up with the counts shown in the same cycle.

Top module: `vga_scan_gen`

## Requirements
- R1: The column count `hcount` advances by one per clock from 0 to 126 and then returns to 0, so a line lasts 127 clocks.
- R2: The row count `vcount` holds its value except in the clock where `hcount` is 126. In that clock it advances by one, and after row 524 it returns to 0, so a frame lasts 525 lines.
- R3: `fb_addr` equals `vcount` in bits 16:7 concatenated with `hcount` in bits 6:0, in the same cycle as the counts.
- R4: `hblank` is 1 exactly when `hcount` is in 100..126. `vblank` is 1 exactly when `vcount` is in 480..524.
- R5: With the default active-low polarity, `hsync` is 0 (asserted) exactly when `hcount` is in 106..117. `vsync` is 0 exactly when `vcount` is 490 or 491. Otherwise both are 1.
- R6: `vsync` changes level only in cycles where `hcount` is 0, and `hsync` is deasserted in any cycle where `vsync` changes level.
- R7: `mark_px` is 1 exactly when `hcount` equals 64.
- R8: While `rst_n` is 0 at a rising edge, both counts become 0. In that case every decoded output shows the value it has for counts of zero: blanks 0, syncs 1, marker 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock (4 MHz in the intended system) |
| rst_n | input | 1 | Synchronous reset, active low |
| hsync | output | 1 | Horizontal sync, registered, active low by default |
| vsync | output | 1 | Vertical sync, registered, active low by default |
| hblank | output | 1 | High over the non-displayed columns |
| vblank | output | 1 | High over the non-displayed rows |
| hcount | output | 7 | Current column |
| vcount | output | 10 | Current row |
| fb_addr | output | 17 | Frame-buffer address {row, column} |
| mark_px | output | 1 | Test pattern, high at column 64 only |

## Verification
The main stimulus is one uninterrupted pass over a whole frame plus part of the next. Every column of every row is compared against counts and windows computed arithmetically in the bench. This exposes off-by-one errors at each window boundary (99/100, 105/106, 117/118, 479/480, 489/490, 491/492) as well as at both counter wraps. A second pattern asserts reset in the middle of a frame, at a nonzero row and column. This separates a true synchronous clear from a counter that only happens to pass through zero, and it confirms that the registered decodes follow the counts at once. Each change of the vertical sync level is also checked against the column count and the horizontal sync level at that moment. This catches a horizontal pulse that coincides with the edge of the vertical pulse.

// File: rtl/vga_scan_pkg.sv
// Package: shared helpers for the raster timing generator.
// Assumes: all boundary values fit in a 32-bit signed int.
package vga_scan_pkg;

    // Half-open window test: lo <= v < hi.
    function automatic logic in_span(input int v, input int lo, input int hi);
        return (v >= lo) && (v < hi);
    endfunction

    // Bits needed to hold values 0 .. n-1.
    function automatic int bits_for(input int n);
        return (n <= 2) ? 1 : $clog2(n);
    endfunction

endpackage

// File: rtl/vga_scan_counter.sv
// Module: wrapping up-counter with an advance enable.
// Counts 0 .. TOTAL-1 and wraps. It also exposes its next-state value, so that
// registered decoders can line up with the count in the same cycle.
// Assumes: TOTAL <= 2**W; synchronous active-low reset.
module vga_scan_counter #(
    parameter int W     = 7,
    parameter int TOTAL = 127
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         adv,
    output logic [W-1:0] count,
    output logic [W-1:0] count_nxt,
    output logic         at_last
);
    localparam logic [W-1:0] LAST = W'(TOTAL - 1);
    localparam logic [W-1:0] ONE  = W'(1);

    // Next-state: hold, step, or wrap to zero; forced to zero in reset.
    always_comb begin
        at_last = (count == LAST);
        if (!rst_n)
            count_nxt = '0;
        else if (!adv)
            count_nxt = count;
        else if (at_last)
            count_nxt = '0;
        else
            count_nxt = count + ONE;
    end

    // State register.
    always_ff @(posedge clk) begin
        count <= count_nxt;
    end

endmodule

// File: rtl/vga_scan_window.sv
// Module: registered window decoder.
// The flag is active while the next count lies in [START, STOP), so the
// registered output matches the count register in the same cycle.
// ACTIVE_LOW selects inverted output polarity.
// Assumes: the driving counter forces its next value to zero in reset.
module vga_scan_window
    import vga_scan_pkg::*;
#(
    parameter int W          = 7,
    parameter int START      = 0,
    parameter int STOP       = 1,
    parameter bit ACTIVE_LOW = 1'b0
) (
    input  logic         clk,
    input  logic [W-1:0] count_nxt,
    output logic         flag
);
    logic hit;
    logic lvl;

    // Window membership of the upcoming count.
    always_comb begin
        hit = in_span(int'(count_nxt), START, STOP);
    end

    // Polarity variant chosen at elaboration.
    generate
        if (ACTIVE_LOW) begin : g_low
            assign lvl = ~hit;
        end else begin : g_high
            assign lvl = hit;
        end
    endgenerate

    // Glitch-free output register.
    always_ff @(posedge clk) begin
        flag <= lvl;
    end

endmodule

// File: rtl/vga_scan_gen.sv
// Module: raster timing and frame-address generator (top).
// A column counter feeds a row counter. The sync, blank and marker outputs are
// registered decodes of the counters' next state. The frame address is the
// row count concatenated above the column count.
// Assumes: the sync windows sit strictly inside a line, never at column 0,
// so that every horizontal pulse falls inside the vertical pulse.
module vga_scan_gen #(
    parameter int H_TOTAL      = 127,
    parameter int V_TOTAL      = 525,
    parameter int H_VIS        = 100,
    parameter int H_SYNC_BEG   = 106,
    parameter int H_SYNC_END   = 118,
    parameter int V_VIS        = 480,
    parameter int V_SYNC_BEG   = 490,
    parameter int V_SYNC_END   = 492,
    parameter int MARK_COL     = 64,
    parameter bit SYNC_ACT_LOW = 1'b1,
    parameter int H_BITS       = vga_scan_pkg::bits_for(H_TOTAL),
    parameter int V_BITS       = vga_scan_pkg::bits_for(V_TOTAL)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    output logic                     hsync,
    output logic                     vsync,
    output logic                     hblank,
    output logic                     vblank,
    output logic [H_BITS-1:0]        hcount,
    output logic [V_BITS-1:0]        vcount,
    output logic [H_BITS+V_BITS-1:0] fb_addr,
    output logic                     mark_px
);
    logic [H_BITS-1:0] h_nxt;
    logic [V_BITS-1:0] v_nxt;
    logic              h_last;
    logic              v_last;

    // Column counter: always advances.
    vga_scan_counter #(.W(H_BITS), .TOTAL(H_TOTAL)) u_hcnt (
        .clk(clk), .rst_n(rst_n), .adv(1'b1),
        .count(hcount), .count_nxt(h_nxt), .at_last(h_last)
    );

    // Row counter: advances on the column wrap.
    vga_scan_counter #(.W(V_BITS), .TOTAL(V_TOTAL)) u_vcnt (
        .clk(clk), .rst_n(rst_n), .adv(h_last),
        .count(vcount), .count_nxt(v_nxt), .at_last(v_last)
    );

    // Horizontal blank over the columns past the visible span.
    vga_scan_window #(.W(H_BITS), .START(H_VIS), .STOP(H_TOTAL), .ACTIVE_LOW(1'b0)) u_hblk (
        .clk(clk), .count_nxt(h_nxt), .flag(hblank)
    );

    // Vertical blank over the rows past the visible span.
    vga_scan_window #(.W(V_BITS), .START(V_VIS), .STOP(V_TOTAL), .ACTIVE_LOW(1'b0)) u_vblk (
        .clk(clk), .count_nxt(v_nxt), .flag(vblank)
    );

    // Horizontal sync pulse.
    vga_scan_window #(.W(H_BITS), .START(H_SYNC_BEG), .STOP(H_SYNC_END), .ACTIVE_LOW(SYNC_ACT_LOW)) u_hsyn (
        .clk(clk), .count_nxt(h_nxt), .flag(hsync)
    );

    // Vertical sync pulse.
    vga_scan_window #(.W(V_BITS), .START(V_SYNC_BEG), .STOP(V_SYNC_END), .ACTIVE_LOW(SYNC_ACT_LOW)) u_vsyn (
        .clk(clk), .count_nxt(v_nxt), .flag(vsync)
    );

    // Single-column test marker.
    vga_scan_window #(.W(H_BITS), .START(MARK_COL), .STOP(MARK_COL + 1), .ACTIVE_LOW(1'b0)) u_mark (
        .clk(clk), .count_nxt(h_nxt), .flag(mark_px)
    );

    // Linear frame address: row above column.
    always_comb begin
        fb_addr = {vcount, hcount};
    end

endmodule

// File: rtl/vga_scan_chk.sv
// Module: property checker for vga_scan_gen, attached with bind.
// Assumes: the same parameter values as the bound instance.
module vga_scan_chk #(
    parameter int H_TOTAL      = 127,
    parameter int V_TOTAL      = 525,
    parameter int H_VIS        = 100,
    parameter int V_VIS        = 480,
    parameter int MARK_COL     = 64,
    parameter bit SYNC_ACT_LOW = 1'b1,
    parameter int H_BITS       = 7,
    parameter int V_BITS       = 10
) (
    input logic              clk,
    input logic              rst_n,
    input logic              hsync,
    input logic              vsync,
    input logic              hblank,
    input logic              vblank,
    input logic [H_BITS-1:0] hcount,
    input logic [V_BITS-1:0] vcount,
    input logic              mark_px
);
    localparam logic [H_BITS-1:0] H_LAST = H_BITS'(H_TOTAL - 1);
    localparam logic [V_BITS-1:0] V_LAST = V_BITS'(V_TOTAL - 1);
    localparam logic [H_BITS-1:0] H_ONE  = H_BITS'(1);
    localparam logic [V_BITS-1:0] V_ONE  = V_BITS'(1);
    localparam logic [H_BITS-1:0] H_MARK = H_BITS'(MARK_COL);
    localparam logic [H_BITS-1:0] H_VISL = H_BITS'(H_VIS);
    localparam logic [V_BITS-1:0] V_VISL = V_BITS'(V_VIS);
    localparam logic              SYNC_ON = ~SYNC_ACT_LOW;

    AST_H_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (hcount != H_LAST) |=> (hcount == $past(hcount) + H_ONE)); // R1
    AST_H_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (hcount == H_LAST) |=> (hcount == '0)); // R1
    AST_V_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (hcount != H_LAST) |=> $stable(vcount)); // R2
    AST_V_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (hcount == H_LAST && vcount != V_LAST) |=> (vcount == $past(vcount) + V_ONE)); // R2
    AST_V_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (hcount == H_LAST && vcount == V_LAST) |=> (vcount == '0)); // R2
    AST_HBLANK: assert property (@(posedge clk) disable iff (!rst_n)
        hblank == (hcount >= H_VISL)); // R4
    AST_VBLANK: assert property (@(posedge clk) disable iff (!rst_n)
        vblank == (vcount >= V_VISL)); // R4
    AST_VS_EDGE_COL0: assert property (@(posedge clk) disable iff (!rst_n)
        (vsync != $past(vsync)) |-> (hcount == '0)); // R6
    AST_HS_INSIDE_VS: assert property (@(posedge clk) disable iff (!rst_n)
        (vsync != $past(vsync)) |-> (hsync != SYNC_ON)); // R6
    AST_MARK_COL: assert property (@(posedge clk) disable iff (!rst_n)
        mark_px |-> (hcount == H_MARK)); // R7
    AST_RESET_CLEAR: assert property (@(posedge clk)
        !rst_n |=> (hcount == '0 && vcount == '0 && !hblank && !vblank && !mark_px)); // R8

endmodule

bind vga_scan_gen vga_scan_chk #(
    .H_TOTAL(H_TOTAL), .V_TOTAL(V_TOTAL), .H_VIS(H_VIS), .V_VIS(V_VIS),
    .MARK_COL(MARK_COL), .SYNC_ACT_LOW(SYNC_ACT_LOW),
    .H_BITS(H_BITS), .V_BITS(V_BITS)
) u_vga_scan_chk (
    .clk(clk), .rst_n(rst_n), .hsync(hsync), .vsync(vsync),
    .hblank(hblank), .vblank(vblank), .hcount(hcount), .vcount(vcount),
    .mark_px(mark_px)
);

// File: tb/test_vga_scan_gen.sv
// Bench: full-frame sweep of vga_scan_gen at default parameters, with
// expected values computed arithmetically from the requirements.
module test_vga_scan_gen;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        hsync, vsync, hblank, vblank, mark_px;
    logic [6:0]  hcount;
    logic [9:0]  vcount;
    logic [16:0] fb_addr;

    int vectors = 0;
    int fails   = 0;
    bit done    = 1'b0;
    int h_m, v_m;

    always #2 clk = ~clk;

    vga_scan_gen i_vga_scan_gen (
        .clk(clk), .rst_n(rst_n), .hsync(hsync), .vsync(vsync),
        .hblank(hblank), .vblank(vblank), .hcount(hcount), .vcount(vcount),
        .fb_addr(fb_addr), .mark_px(mark_px)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        vectors++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s at h=%0d v=%0d: actual %0d expected %0d", req, what, h_m, v_m, act, exp);
        end
    endtask

    // Compare every output against the model counts h_m, v_m.
    task automatic check_all();
        chk("R1", "hcount", int'(hcount), h_m);
        chk("R2", "vcount", int'(vcount), v_m);
        chk("R3", "fb_addr", int'(fb_addr), v_m * 128 + h_m);
        chk("R4", "hblank", int'(hblank), (h_m >= 100) ? 1 : 0);
        chk("R4", "vblank", int'(vblank), (v_m >= 480) ? 1 : 0);
        chk("R5", "hsync", int'(hsync), (h_m >= 106 && h_m <= 117) ? 0 : 1);
        chk("R5", "vsync", int'(vsync), (v_m == 490 || v_m == 491) ? 0 : 1);
        chk("R7", "mark_px", int'(mark_px), (h_m == 64) ? 1 : 0);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    endtask

    // Advance the model by one pixel clock.
    task automatic model_step();
        if (h_m == 126) begin
            h_m = 0;
            v_m = (v_m == 524) ? 0 : v_m + 1;
        end else begin
            h_m = h_m + 1;
        end
    endtask

    initial begin
        logic prev_vs;
        h_m = 0;
        v_m = 0;
        // R8: reset state.
        repeat (4) @(posedge clk);
        @(negedge clk);
        check_all();
        rst_n = 1'b1;
        prev_vs = vsync;
        // R1 R2 R3 R4 R5 R7: one full frame plus part of the next.
        for (int i = 0; i < 127 * 525 + 700; i++) begin
            @(posedge clk);
            model_step();
            @(negedge clk);
            check_all();
            // R6: vsync level changes only at column 0 with hsync idle.
            if (vsync != prev_vs) begin
                chk("R6", "col at vsync edge", int'(hcount), 0);
                chk("R6", "hsync at vsync edge", int'(hsync), 1);
            end
            prev_vs = vsync;
        end
        // R8: reset in mid-frame from a nonzero position.
        chk("R8", "nonzero before reset", (h_m != 0 && v_m != 0) ? 1 : 0, 1);
        rst_n = 1'b0;
        @(posedge clk);
        h_m = 0;
        v_m = 0;
        @(negedge clk);
        check_all();
        rst_n = 1'b1;
        for (int i = 0; i < 300; i++) begin
            @(posedge clk);
            model_step();
            @(negedge clk);
            check_all();
        end
        finish_run();
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired: actual timeout expected completion");
        finish_run();
    end

endmodule